// File: doc/BRIEF.md
# Quasi-Bidirectional I2C Port Expander

This block is an I2C target that controls a five-pin quasi-bidirectional port. The SCL and SDA inputs are already synchronised to the system clock. The block samples them, recognises START and STOP conditions, and compares the first byte of each transfer against a fixed 7-bit address. On a write, the single data byte that follows the address becomes the port latch value. On a read, the block shifts out the present pin levels, most significant bit first.

The block never acknowledges. The ninth clock of every byte is left released, so a master must ignore the level it sees in that slot. There is no direction register; each pin's behaviour comes from its latch bit:

- A latch bit of zero drives the pin low.
- A latch bit of one releases the pin, so an external pull-up takes it high.
- A released pin can be used as an input: something outside can pull it low, and a read then reports the true level.

Top module: `qbx_expander`

## Requirements
- R1: After reset the latch holds all ones, so no pin is driven (pin_oe_o = 0), and SDA is released (sda_oe_o = 0).
- R2: A START is SDA falling while SCL was high in the previous and current cycle. It restarts address reception with the bit count at zero, including in the middle of a transfer. An SDA change in the same cycle that SCL rises is taken as a data bit, not as START or STOP.
- R3: A STOP is SDA rising while SCL is high. It returns the block to idle. A STOP that arrives before all eight data bits have been sampled leaves the latch unchanged.
- R4: The address byte is compared in full, so only 0xAC (write) and 0xAD (read) are accepted, with R/W in bit 0. On any other address the block leaves the latch alone and does not drive SDA until the next START or STOP.
- R5: In a write, data bits are sampled on rising SCL, MSB first. On the eighth rising edge, bits 4:0 of the byte load the latch. Bits 7:5 are ignored.
- R6: Only the first data byte after a write address is stored. Any later bytes before STOP have no effect on the latch.
- R7: SDA is released during the ninth clock of every byte, whether it is an address, write data or read data byte.
- R8: A read returns one byte, MSB first, where bit n is the level of pin n for n < 5 and bits 7:5 are zero (driven low). The pin levels are captured at the falling SCL edge that ends the address acknowledge slot. SDA changes only while SCL is low.
- R9: A pin whose latch bit is 0 is driven low (pin_oe_o[n] = 1). A pin whose latch bit is 1 is released, and a read reports its external level.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Synchronised SCL level |
| sda_i | input | 1 | Synchronised SDA level (wired line) |
| sda_oe_o | output | 1 | 1 pulls SDA low |
| pin_i | input | NUM_PINS | Pad levels of the port pins |
| pin_oe_o | output | NUM_PINS | 1 drives the pin low (latch bit is 0) |

## Verification
Two bus events can land in one system cycle: an SCL rising edge and an SDA transition. The block must treat that case as a data sample, not as a START or STOP. The bench provokes this with a whole write transfer in which SDA and SCL change on the same clock. The test passes only if the latch ends up holding the intended byte.

A second overlap is a repeated START that arrives part way through a byte, where address reception and data reception compete. The test passes only if the data byte that follows the restart is the one stored.

// File: rtl/qbx_pkg.sv
package qbx_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_WR,
    ST_RD,
    ST_SKIP
  } qbx_state_e;
endpackage

// File: rtl/qbx_bus_cond.sv
module qbx_bus_cond (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o,
  output logic scl_hi_o
);
  logic scl_q, sda_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
    end
  end

  assign scl_rise_o = scl_i & ~scl_q;
  assign scl_fall_o = ~scl_i & scl_q;
  // SCL high on both samples: SDA edge is a bus condition
  assign start_o    = scl_i & scl_q & sda_q & ~sda_i;
  assign stop_o     = scl_i & scl_q & ~sda_q & sda_i;
  assign scl_hi_o   = scl_q;
endmodule

// File: rtl/qbx_shifter.sv
module qbx_shifter #(
  parameter int BYTE_W = 8,
  localparam int CNT_W = $clog2(BYTE_W + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              load_i,
  input  logic [BYTE_W-1:0] load_val_i,
  input  logic              rise_i,
  input  logic              fall_i,
  input  logic              tx_i,
  input  logic              sda_i,
  output logic [CNT_W-1:0]  cnt_o,
  output logic [BYTE_W-1:0] next_o,
  output logic              msb_o
);
  logic [BYTE_W-1:0] sh_q;
  logic [CNT_W-1:0]  cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q  <= '1;
      cnt_q <= '0;
    end else if (load_i) begin
      sh_q  <= load_val_i;
      cnt_q <= '0;
    end else if (clr_i) begin
      cnt_q <= '0;
    end else begin
      if (rise_i) begin
        cnt_q <= cnt_q + 1'b1;
        if (!tx_i) sh_q <= {sh_q[BYTE_W-2:0], sda_i};
      end
      if (fall_i && tx_i) sh_q <= {sh_q[BYTE_W-2:0], 1'b0};
    end
  end

  assign cnt_o  = cnt_q;
  assign next_o = {sh_q[BYTE_W-2:0], sda_i};
  assign msb_o  = sh_q[BYTE_W-1];
endmodule

// File: rtl/qbx_port.sv
module qbx_port #(
  parameter int NUM_PINS = 5,
  parameter int BYTE_W   = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                wr_en_i,
  input  logic [NUM_PINS-1:0] wr_data_i,
  input  logic [NUM_PINS-1:0] pin_i,
  output logic [NUM_PINS-1:0] pin_oe_o,
  output logic [BYTE_W-1:0]   rd_byte_o
);
  logic [NUM_PINS-1:0] latch_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      latch_q <= '1;
    else if (wr_en_i) latch_q <= wr_data_i;
  end

  // zero drives low, one releases to the pull-up
  assign pin_oe_o = ~latch_q;

  always_comb begin
    rd_byte_o = '0;
    rd_byte_o[NUM_PINS-1:0] = pin_i;
  end

  // R5
  latch_wr_only_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pin_oe_o != $past(pin_oe_o)) |-> $past(wr_en_i));
endmodule

// File: rtl/qbx_expander.sv
module qbx_expander
  import qbx_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h56,
  parameter int         NUM_PINS = 5,
  parameter int         BYTE_W   = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                scl_i,
  input  logic                sda_i,
  output logic                sda_oe_o,
  input  logic [NUM_PINS-1:0] pin_i,
  output logic [NUM_PINS-1:0] pin_oe_o
);
  localparam int CNT_W = $clog2(BYTE_W + 1);

  qbx_state_e        state_q;
  logic              rw_q, ack_hi_q;
  logic              scl_rise, scl_fall, start, stop, scl_hi;
  logic [CNT_W-1:0]  cnt;
  logic [BYTE_W-1:0] next_byte, rd_byte;
  logic              msb, last_rise, ack_end, addr_hit;
  logic              sh_clr, sh_load, wr_en;

  qbx_bus_cond u_cond (
    .clk_i, .rst_ni, .scl_i, .sda_i,
    .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
    .start_o(start), .stop_o(stop), .scl_hi_o(scl_hi)
  );

  assign last_rise = scl_rise && (cnt == CNT_W'(BYTE_W - 1));
  assign ack_end   = (state_q == ST_ADDR_ACK) && scl_fall && ack_hi_q;
  assign addr_hit  = (next_byte[BYTE_W-1:1] == DEV_ADDR);
  assign sh_clr    = start || (ack_end && !rw_q);
  assign sh_load   = ack_end && rw_q && !start;
  assign wr_en     = (state_q == ST_WR) && last_rise && !start && !stop;

  qbx_shifter #(.BYTE_W(BYTE_W)) u_shift (
    .clk_i, .rst_ni,
    .clr_i(sh_clr), .load_i(sh_load), .load_val_i(rd_byte),
    .rise_i(scl_rise), .fall_i(scl_fall), .tx_i(state_q == ST_RD),
    .sda_i, .cnt_o(cnt), .next_o(next_byte), .msb_o(msb)
  );

  qbx_port #(.NUM_PINS(NUM_PINS), .BYTE_W(BYTE_W)) u_port (
    .clk_i, .rst_ni,
    .wr_en_i(wr_en), .wr_data_i(next_byte[NUM_PINS-1:0]),
    .pin_i, .pin_oe_o, .rd_byte_o(rd_byte)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      rw_q     <= 1'b0;
      ack_hi_q <= 1'b0;
    end else if (start) begin
      state_q <= ST_ADDR;
    end else if (stop) begin
      state_q <= ST_IDLE;
    end else begin
      unique case (state_q)
        ST_ADDR: if (last_rise) begin
          if (addr_hit) begin
            state_q  <= ST_ADDR_ACK;
            rw_q     <= next_byte[0];
            ack_hi_q <= 1'b0;
          end else begin
            state_q <= ST_SKIP;
          end
        end
        // ninth clock left released; move on after its falling edge
        ST_ADDR_ACK: begin
          if (scl_rise) ack_hi_q <= 1'b1;
          else if (ack_end) state_q <= rw_q ? ST_RD : ST_WR;
        end
        ST_WR: if (last_rise) state_q <= ST_SKIP;
        ST_RD: if (scl_fall && cnt == CNT_W'(BYTE_W)) state_q <= ST_SKIP;
        default: ;
      endcase
    end
  end

  assign sda_oe_o = (state_q == ST_RD) && !msb;

  // R2
  start_rst_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start |=> (state_q == ST_ADDR && cnt == '0));
  // R3
  stop_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop |=> state_q == ST_IDLE);
  // R8
  sda_low_phase_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sda_oe_o != $past(sda_oe_o)) |-> !scl_hi);
  // R8
  rd_pad_bits_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_RD && cnt < CNT_W'(BYTE_W - NUM_PINS)) |-> sda_oe_o);
  // R7
  ack_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_ADDR_ACK || state_q == ST_WR && cnt == CNT_W'(BYTE_W)) |-> !sda_oe_o);
endmodule

// File: tb/sim_qbx_expander.sv
module sim_qbx_expander;
  localparam int Q = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       m_scl = 1'b1, m_sda = 1'b1;
  logic [4:0] ext_lvl = 5'h1F;
  logic       sda_oe;
  logic [4:0] pin_oe, pin_lvl;
  logic       sda_line;
  logic       oe_seen = 1'b0;
  logic       done = 1'b0;

  int checks = 0, errors = 0;

  typedef struct { string req; int exp; } item_t;
  item_t exp_q[$];
  int    obs;
  event  txn_done;

  always #4 clk = ~clk;

  assign sda_line = m_sda & ~sda_oe;
  assign pin_lvl  = ext_lvl & ~pin_oe;

  qbx_expander u0 (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(m_scl), .sda_i(sda_line),
    .sda_oe_o(sda_oe), .pin_i(pin_lvl), .pin_oe_o(pin_oe)
  );

  always @(negedge clk) if (sda_oe) oe_seen <= 1'b1;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic hold();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bus_start();
    m_sda = 1'b1; m_scl = 1'b1; hold();
    m_sda = 1'b0; hold();
    m_scl = 1'b0; hold();
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; hold();
    m_scl = 1'b1; hold();
    m_sda = 1'b1; hold();
  endtask

  task automatic put_bit(input bit b, input bit same);
    m_sda = b;
    if (!same) hold();
    m_scl = 1'b1; hold();
    m_scl = 1'b0; hold();
  endtask

  task automatic get_bit(output bit b);
    m_sda = 1'b1; hold();
    m_scl = 1'b1; hold();
    b = sda_line;
    m_scl = 1'b0; hold();
  endtask

  // ninth slot: line must stay released (R7)
  task automatic put_byte(input logic [7:0] v, input bit same);
    bit a;
    for (int i = 7; i >= 0; i--) put_bit(v[i], same);
    get_bit(a);
    chk(a == 1'b1, "R7 ack slot released", int'(a), 1);
  endtask

  task automatic get_byte(output logic [7:0] v);
    bit b;
    for (int i = 7; i >= 0; i--) begin
      get_bit(b);
      v[i] = b;
    end
    put_bit(1'b1, 1'b0);
  endtask

  task automatic post(input string req, input int exp, input int o);
    item_t it;
    it.req = req; it.exp = exp;
    exp_q.push_back(it);
    obs = o;
    ->txn_done;
    @(negedge clk);
  endtask

  task automatic write_txn(input logic [7:0] addr, input logic [7:0] d,
                           input int exp, input string req, input bit same);
    bus_start();
    put_byte(addr, same);
    put_byte(d, same);
    bus_stop();
    hold();
    post(req, exp, int'({3'b0, ~pin_oe}));
  endtask

  task automatic read_txn(input logic [7:0] addr, input int exp, input string req);
    logic [7:0] v;
    bus_start();
    put_byte(addr, 1'b0);
    get_byte(v);
    bus_stop();
    hold();
    post(req, exp, int'(v));
  endtask

  // scoreboard monitor
  initial begin
    forever begin
      @(txn_done);
      if (exp_q.size() == 0) begin
        chk(1'b0, "scoreboard empty", obs, -1);
      end else begin
        item_t it;
        it = exp_q.pop_front();
        chk(obs == it.exp, it.req, obs, it.exp);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      chk(1'b0, "watchdog", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(pin_oe == 5'h00, "R1 pins released after reset", int'(pin_oe), 0);
    chk(sda_oe == 1'b0, "R1 sda released in reset", int'(sda_oe), 0);
    rst_n = 1'b1;
    hold();
    chk(pin_oe == 5'h00 && sda_oe == 1'b0, "R1 idle after reset", int'({sda_oe, pin_oe}), 0);

    write_txn(8'hAC, 8'h0A, 'h0A, "R5 write latch", 1'b0);
    chk(pin_oe == 5'b10101, "R9 zero bits drive low", int'(pin_oe), 'h15);

    write_txn(8'hAC, 8'hF5, 'h15, "R5 upper bits ignored", 1'b0);

    ext_lvl = 5'h1F;
    read_txn(8'hAD, 'h15, "R8 R9 read driven and released pins");

    write_txn(8'hAC, 8'h1F, 'h1F, "R5 release all", 1'b0);
    ext_lvl = 5'b00110;
    read_txn(8'hAD, 'h06, "R9 external levels on released pins");
    ext_lvl = 5'h1F;
    read_txn(8'hAD, 'h1F, "R8 upper bits read zero");

    write_txn(8'hA4, 8'h00, 'h1F, "R4 foreign write address ignored", 1'b0);
    oe_seen = 1'b0;
    read_txn(8'hA5, 'hFF, "R4 foreign read leaves line released");
    chk(oe_seen == 1'b0, "R4 no drive on foreign read", int'(oe_seen), 0);
    write_txn(8'hAE, 8'h00, 'h1F, "R4 address bit 1 compared", 1'b0);

    bus_start();
    put_byte(8'hAC, 1'b0);
    put_byte(8'h13, 1'b0);
    put_byte(8'h0C, 1'b0);
    bus_stop();
    hold();
    post("R6 second byte ignored", 'h13, int'({3'b0, ~pin_oe}));

    bus_start();
    put_byte(8'hAC, 1'b0);
    for (int i = 0; i < 5; i++) put_bit(1'b0, 1'b0);
    bus_stop();
    hold();
    post("R3 stop before byte end", 'h13, int'({3'b0, ~pin_oe}));

    bus_start();
    put_byte(8'hAC, 1'b0);
    for (int i = 0; i < 3; i++) put_bit(1'b1, 1'b0);
    bus_start();
    put_byte(8'hAC, 1'b0);
    put_byte(8'h0C, 1'b0);
    bus_stop();
    hold();
    post("R2 repeated start mid byte", 'h0C, int'({3'b0, ~pin_oe}));

    write_txn(8'hAC, 8'h19, 'h19, "R2 sda edge with scl rise is data", 1'b1);
    read_txn(8'hAD, 'h19, "R8 read after same-cycle write");

    hold();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule